// File: doc/BRIEF.md
# Hamming-Guarded Instruction Cache Line Store

This block holds the lines of a small instruction cache together with a 10-bit Hamming check code for each line. When a line is written through the fill port, the block computes the code over three things: the line's data word, its tag, and the index it is stored at. It keeps that code next to the line, along with a flag that says whether the line was filled while protection was on. When the processor fetches a line, the block computes the code again from what it has stored and XORs it with the stored code. A nonzero result turns the fetch response into an error, records the line index and the syndrome in a sticky status register, and raises an interrupt. The block does not correct errors. Miss handling and replacement are the job of the surrounding cache.

A separate debug port reads and writes the raw contents: data, tag and stored code. Debug accesses never compute a code and never compare one. Because of this, a debug write is also a direct way to corrupt a protected line. Software clears the status by pulsing the clear input. If a new error arrives in the same cycle as a clear, the new error is recorded.

Top module: `hamm_icache_guard`

## Requirements
- R1: A fill with `prot_en`=1 stores a code over the message {index, tag, data}, with data in the low bits. Message bit i sits at the i-th position, counting up from 3, that is not a power of two. Code bit j is the XOR of the message bits whose position has bit j set. A debug read returns this code.
- R2: A fetch presented in cycle N gives `fetch_rvalid`=1 after the next clock edge, together with the stored data and tag of that index. Otherwise `fetch_rvalid` is 0.
- R3: For a fetch with `prot_en`=1 from a checked line, the syndrome is the stored code XOR the recomputed code. `fetch_err` is 1 exactly when the syndrome is nonzero.
- R4: Every single-bit and every double-bit change to the stored data or tag of a checked line makes its next fetch report an error.
- R5: On a fetch error, `stat_err`, `stat_idx` and `stat_syn` update on the same edge as `fetch_err`. `irq` follows `stat_err`.
- R6: The status is sticky. A later error does not overwrite it. `stat_clr` clears the status, but an error in the same cycle as the clear is recorded instead.
- R7: A debug read returns the raw data, tag and code one cycle later and never changes the status.
- R8: A debug write replaces the stored data and tag but leaves the stored code and the checked flag unchanged.
- R9: A fill with `prot_en`=0 marks the line unchecked. Its fetches report no error until it is refilled with `prot_en`=1.
- R10: A fetch made while `prot_en`=0 reports no error.
- R11: After reset, the status, `irq` and both response valids are 0, and every line is unchecked.
- R12: If a fill and a debug write hit the same index in the same cycle, the fill's contents and code are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prot_en | input | 1 | Protection enable |
| fill_valid | input | 1 | Fill write strobe |
| fill_idx | input | IDX_W | Fill line index |
| fill_tag | input | TAG_W | Fill tag |
| fill_data | input | DATA_W | Fill data |
| fetch_valid | input | 1 | Processor fetch strobe |
| fetch_idx | input | IDX_W | Fetch line index |
| fetch_rvalid | output | 1 | Fetch response valid |
| fetch_data | output | DATA_W | Fetched data |
| fetch_tag | output | TAG_W | Fetched tag |
| fetch_err | output | 1 | Fetch error response |
| dbg_valid | input | 1 | Debug access strobe |
| dbg_we | input | 1 | Debug write (1) or read (0) |
| dbg_idx | input | IDX_W | Debug line index |
| dbg_wtag | input | TAG_W | Debug write tag |
| dbg_wdata | input | DATA_W | Debug write data |
| dbg_rvalid | output | 1 | Debug read response valid |
| dbg_rdata | output | DATA_W | Raw stored data |
| dbg_rtag | output | TAG_W | Raw stored tag |
| dbg_rcode | output | CODE_W | Raw stored code |
| stat_clr | input | 1 | Clear status (write-1 pulse) |
| stat_err | output | 1 | Sticky error flag |
| stat_idx | output | IDX_W | Index of the recorded error |
| stat_syn | output | CODE_W | Syndrome of the recorded error |
| irq | output | 1 | Error interrupt |

## Verification
Suppose a stored code or a checked flag goes wrong. The first fetch of the affected line shows it on `fetch_err`, one cycle after the request, and the status updates on the same edge. A wrong encoder bit shows up on a debug read as a code that differs from the arithmetic reference. It also shows up as a syndrome that differs from the XOR of the reference codes of the original and corrupted contents. A status that loses stickiness, or that debug traffic disturbs, shows up as a changed `stat_idx` or `stat_err` on the next sample after that access.

// File: rtl/hamm_icache_guard.sv
module hamm_icache_guard #(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 20,
  parameter int IDX_W  = 8,
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_en,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fetch_valid,
  input  logic [IDX_W-1:0]  fetch_idx,
  output logic              fetch_rvalid,
  output logic [DATA_W-1:0] fetch_data,
  output logic [TAG_W-1:0]  fetch_tag,
  output logic              fetch_err,
  input  logic              dbg_valid,
  input  logic              dbg_we,
  input  logic [IDX_W-1:0]  dbg_idx,
  input  logic [TAG_W-1:0]  dbg_wtag,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic              dbg_rvalid,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic [TAG_W-1:0]  dbg_rtag,
  output logic [CODE_W-1:0] dbg_rcode,
  input  logic              stat_clr,
  output logic              stat_err,
  output logic [IDX_W-1:0]  stat_idx,
  output logic [CODE_W-1:0] stat_syn,
  output logic              irq
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int MSG_W = IDX_W + TAG_W + DATA_W;
  localparam int LAST  = MSG_W + CODE_W + 1;

  function automatic logic [CODE_W-1:0] encode(input logic [MSG_W-1:0] msg);
    logic [CODE_W-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 3; p <= LAST; p++) begin
      if ((p & (p - 1)) != 0 && k < MSG_W) begin
        for (int j = 0; j < CODE_W; j++)
          if (((p >> j) & 1) == 1) c[j] = c[j] ^ msg[k];
        k++;
      end
    end
    return c;
  endfunction

  logic [DATA_W-1:0] mem_data [DEPTH];
  logic [TAG_W-1:0]  mem_tag  [DEPTH];
  logic [CODE_W-1:0] mem_code [DEPTH];
  logic [DEPTH-1:0]  mem_chk;

  always_ff @(posedge clk) begin
    if (dbg_valid && dbg_we) begin
      mem_data[dbg_idx] <= dbg_wdata;
      mem_tag[dbg_idx]  <= dbg_wtag;
    end
    if (fill_valid) begin
      mem_data[fill_idx] <= fill_data;
      mem_tag[fill_idx]  <= fill_tag;
      if (prot_en) mem_code[fill_idx] <= encode({fill_idx, fill_tag, fill_data});
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mem_chk <= '0;
    else if (fill_valid) mem_chk[fill_idx] <= prot_en;

  wire [CODE_W-1:0] syn = mem_code[fetch_idx] ^
                          encode({fetch_idx, mem_tag[fetch_idx], mem_data[fetch_idx]});
  wire hit_err = fetch_valid && prot_en && mem_chk[fetch_idx] && (syn != '0);

  always_ff @(posedge clk) begin
    if (fetch_valid) begin
      fetch_data <= mem_data[fetch_idx];
      fetch_tag  <= mem_tag[fetch_idx];
    end
    if (dbg_valid && !dbg_we) begin
      dbg_rdata <= mem_data[dbg_idx];
      dbg_rtag  <= mem_tag[dbg_idx];
      dbg_rcode <= mem_code[dbg_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_rvalid <= 1'b0;
      fetch_err    <= 1'b0;
      dbg_rvalid   <= 1'b0;
      stat_err     <= 1'b0;
      stat_idx     <= '0;
      stat_syn     <= '0;
    end else begin
      fetch_rvalid <= fetch_valid;
      fetch_err    <= hit_err;
      dbg_rvalid   <= dbg_valid && !dbg_we;
      if (hit_err && (!stat_err || stat_clr)) begin
        stat_err <= 1'b1;
        stat_idx <= fetch_idx;
        stat_syn <= syn;
      end else if (stat_clr) begin
        stat_err <= 1'b0;
        stat_idx <= '0;
        stat_syn <= '0;
      end
    end
  end

  assign irq = stat_err;
endmodule

// File: rtl/hamm_icache_guard_chk.sv
module hamm_icache_guard_chk #(
  parameter int IDX_W  = 8,
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prot_en,
  input logic              fetch_valid,
  input logic              fetch_rvalid,
  input logic              fetch_err,
  input logic              dbg_valid,
  input logic              stat_clr,
  input logic              stat_err,
  input logic [IDX_W-1:0]  stat_idx,
  input logic [CODE_W-1:0] stat_syn,
  input logic              irq
);
  assert_rvalid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> fetch_rvalid);
  assert_no_stray_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !fetch_rvalid);
  assert_err_has_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_err |-> fetch_rvalid);
  assert_err_recorded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_err |-> (stat_err && irq));
  assert_nonzero_syn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_err) |-> (stat_syn != '0));
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_err && !stat_clr) |=> (stat_err && $stable(stat_idx) && $stable(stat_syn)));
  assert_dbg_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_valid && !fetch_valid && !stat_err) |=> !stat_err);
  assert_off_no_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !prot_en) |=> !fetch_err);
endmodule

bind hamm_icache_guard hamm_icache_guard_chk #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .fetch_valid(fetch_valid),
  .fetch_rvalid(fetch_rvalid), .fetch_err(fetch_err), .dbg_valid(dbg_valid),
  .stat_clr(stat_clr), .stat_err(stat_err), .stat_idx(stat_idx),
  .stat_syn(stat_syn), .irq(irq));

// File: tb/tb_hamm_icache_guard.sv
module tb_hamm_icache_guard;
  localparam int DW = 8, TW = 4, IW = 3, CW = 10, MW = IW + TW + DW;

  logic clk = 0, rst_n = 0, prot_en = 0;
  logic fill_valid = 0, fetch_valid = 0, dbg_valid = 0, dbg_we = 0, stat_clr = 0;
  logic [IW-1:0] fill_idx = 0, fetch_idx = 0, dbg_idx = 0;
  logic [TW-1:0] fill_tag = 0, dbg_wtag = 0;
  logic [DW-1:0] fill_data = 0, dbg_wdata = 0;
  logic fetch_rvalid, fetch_err, dbg_rvalid, stat_err, irq;
  logic [DW-1:0] fetch_data, dbg_rdata;
  logic [TW-1:0] fetch_tag, dbg_rtag;
  logic [CW-1:0] dbg_rcode, stat_syn;
  logic [IW-1:0] stat_idx;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hamm_icache_guard #(.DATA_W(DW), .TAG_W(TW), .IDX_W(IW), .CODE_W(CW)) dut (.*);

  function automatic logic [CW-1:0] ref_code(input logic [IW-1:0] i, input logic [TW-1:0] t,
                                             input logic [DW-1:0] d);
    logic [MW-1:0] m = {i, t, d};
    logic [CW-1:0] c = '0;
    int pos = 3;
    for (int b = 0; b < MW; b++) begin
      while ((pos & (pos - 1)) == 0) pos++;
      for (int j = 0; j < CW; j++) if (pos[j]) c[j] ^= m[b];
      pos++;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [IW-1:0] i, input logic [TW-1:0] t, input logic [DW-1:0] d);
    @(negedge clk); fill_valid = 1; fill_idx = i; fill_tag = t; fill_data = d;
    @(negedge clk); fill_valid = 0;
  endtask

  task automatic dwrite(input logic [IW-1:0] i, input logic [TW-1:0] t, input logic [DW-1:0] d);
    @(negedge clk); dbg_valid = 1; dbg_we = 1; dbg_idx = i; dbg_wtag = t; dbg_wdata = d;
    @(negedge clk); dbg_valid = 0; dbg_we = 0;
  endtask

  task automatic dread(input logic [IW-1:0] i);
    @(negedge clk); dbg_valid = 1; dbg_we = 0; dbg_idx = i;
    @(negedge clk); dbg_valid = 0;
  endtask

  task automatic fetch(input logic [IW-1:0] i);
    @(negedge clk); fetch_valid = 1; fetch_idx = i;
    @(negedge clk); fetch_valid = 0;
  endtask

  task automatic clear();
    @(negedge clk); stat_clr = 1;
    @(negedge clk); stat_clr = 0;
  endtask

  function automatic logic [TW-1:0] tag_of(input int e); return TW'(e * 5 + 3); endfunction
  function automatic logic [DW-1:0] dat_of(input int e); return DW'(e * 37 + 11); endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [TW+DW-1:0] orig, bad;
    repeat (3) @(negedge clk);
    chk("R11 stat_err", stat_err, 0);
    chk("R11 irq", irq, 0);
    chk("R11 fetch_rvalid", fetch_rvalid, 0);
    chk("R11 dbg_rvalid", dbg_rvalid, 0);
    rst_n = 1;
    prot_en = 1;
    dwrite(0, 4'h1, 8'h22);
    fetch(0);
    chk("R11 unchecked after reset", fetch_err, 0);

    for (int e = 0; e < 8; e++) fill(IW'(e), tag_of(e), dat_of(e));
    for (int e = 0; e < 8; e++) begin
      dread(IW'(e));
      chk("R7 dbg_rvalid", dbg_rvalid, 1);
      chk("R1 code", dbg_rcode, ref_code(IW'(e), tag_of(e), dat_of(e)));
      chk("R7 raw data", dbg_rdata, dat_of(e));
      fetch(IW'(e));
      chk("R2 rvalid", fetch_rvalid, 1);
      chk("R2 data", fetch_data, dat_of(e));
      chk("R2 tag", fetch_tag, tag_of(e));
      chk("R3 clean fetch", fetch_err, 0);
    end
    @(negedge clk);
    chk("R2 idle rvalid", fetch_rvalid, 0);

    for (int e = 0; e < 8; e++)
      for (int b = 0; b < TW + DW; b++) begin
        orig = {tag_of(e), dat_of(e)};
        bad = orig ^ (12'(1) << b);
        dwrite(IW'(e), bad[TW+DW-1:DW], bad[DW-1:0]);
        dread(IW'(e));
        chk("R8 code kept", dbg_rcode, ref_code(IW'(e), tag_of(e), dat_of(e)));
        chk("R7 no flag on debug", stat_err, 0);
        fetch(IW'(e));
        chk("R4 single detect", fetch_err, 1);
        chk("R5 stat_err", stat_err, 1);
        chk("R5 irq", irq, 1);
        chk("R5 stat_idx", stat_idx, e);
        chk("R3 syndrome", stat_syn, ref_code(IW'(e), tag_of(e), dat_of(e)) ^
                                      ref_code(IW'(e), bad[TW+DW-1:DW], bad[DW-1:0]));
        clear();
        chk("R6 cleared", stat_err, 0);
        dwrite(IW'(e), orig[TW+DW-1:DW], orig[DW-1:0]);
      end

    for (int b1 = 0; b1 < TW + DW; b1++)
      for (int b2 = b1 + 1; b2 < TW + DW; b2++) begin
        orig = {tag_of(5), dat_of(5)};
        bad = orig ^ (12'(1) << b1) ^ (12'(1) << b2);
        dwrite(5, bad[TW+DW-1:DW], bad[DW-1:0]);
        fetch(5);
        chk("R4 double detect", fetch_err, 1);
        chk("R3 double syndrome", stat_syn, ref_code(5, tag_of(5), dat_of(5)) ^
                                           ref_code(5, bad[TW+DW-1:DW], bad[DW-1:0]));
        clear();
        dwrite(5, orig[TW+DW-1:DW], orig[DW-1:0]);
      end

    dwrite(2, tag_of(2), dat_of(2) ^ 8'h01);
    dwrite(6, tag_of(6) ^ 4'h2, dat_of(6));
    fetch(2);
    fetch(6);
    chk("R6 later error kept out", stat_idx, 2);
    chk("R6 first syndrome", stat_syn, ref_code(2, tag_of(2), dat_of(2)) ^
                                       ref_code(2, tag_of(2), dat_of(2) ^ 8'h01));
    @(negedge clk); stat_clr = 1; fetch_valid = 1; fetch_idx = 6;
    @(negedge clk); stat_clr = 0; fetch_valid = 0;
    chk("R6 error beats clear", stat_err, 1);
    chk("R6 new index", stat_idx, 6);
    clear();

    prot_en = 0;
    fetch(2);
    chk("R10 no check when off", fetch_err, 0);
    chk("R10 status untouched", stat_err, 0);
    prot_en = 1;
    dwrite(2, tag_of(2), dat_of(2));
    dwrite(6, tag_of(6), dat_of(6));

    prot_en = 0;
    fill(3, 4'h9, 8'hA5);
    prot_en = 1;
    dwrite(3, 4'h9, 8'hA4);
    fetch(3);
    chk("R9 unchecked line", fetch_err, 0);
    fill(3, 4'h9, 8'hA5);
    dwrite(3, 4'h9, 8'hA4);
    fetch(3);
    chk("R9 refilled line checked", fetch_err, 1);
    clear();

    @(negedge clk);
    fill_valid = 1; fill_idx = 4; fill_tag = 4'h7; fill_data = 8'h3C;
    dbg_valid = 1; dbg_we = 1; dbg_idx = 4; dbg_wtag = 4'h1; dbg_wdata = 8'hFF;
    @(negedge clk); fill_valid = 0; dbg_valid = 0; dbg_we = 0;
    dread(4);
    chk("R12 fill data wins", dbg_rdata, 8'h3C);
    chk("R12 fill tag wins", dbg_rtag, 4'h7);
    chk("R12 fill code", dbg_rcode, ref_code(4, 4'h7, 8'h3C));
    fetch(4);
    chk("R12 clean fetch", fetch_err, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule